// File: doc/BRIEF.md
# Interleaved Cache-Block Fetch Controller

This controller refills one cache block at a time from a main memory built as four word-interleaved banks. Consecutive word addresses fall in consecutive banks, so the bank index is the low two bits of a word address and the remaining bits select a row inside every bank. When a refill request arrives, the controller drops the two low address bits and sends the row index to all banks at once. The banks then access in parallel. The four resulting 32-bit words are streamed back over a single one-word bus, one word per cycle.

Timing follows a simple model. Sending the address takes one cycle, each bank access takes six cycles, and each word transfer takes one cycle. A refill therefore costs 1 + 6 + 4 = 11 cycles from acceptance to the last word. Fetching the words one after another from a single module would cost 4 × 8 = 32 cycles. Only one refill is in flight at a time. A busy output tells the cache side when a new request can be taken.

Each bank presents the word it read on its own 32-bit data lane. It must hold that word from the end of its access until it receives the next address strobe. The controller reads the lanes directly during the transfer cycles and keeps no copy of the whole block.

Top module: `ilv_block_fetch`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `busy`, `bank_req`, `rsp_valid` and `rsp_last` are all low.
- R2: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. From the cycle after that edge, `busy` is high.
- R3: `bank_req` is high for exactly one cycle, the cycle right after acceptance. In that cycle `bank_row` carries the accepted address with its two low bits removed (`req_addr[ADDR_W-1:2]`).
- R4: The two low bits of `req_addr` are ignored. Requests that differ only in those bits return the same four words in the same order.
- R5: `rsp_valid` first rises eight cycles after the acceptance edge. It stays high for exactly four consecutive cycles, so the last word appears eleven cycles after acceptance.
- R6: The k-th word returned (k = 0..3) is the word that bank k presents on `bank_rdata[32k+31:32k]` for the requested row. Words return in bank order 0, 1, 2, 3.
- R7: `rsp_last` is high only together with the fourth word of a block, and never without `rsp_valid`.
- R8: `busy` stays high through the cycle that shows the last word. It drops in the cycle right after that.
- R9: A request made while `busy` is high is refused. It produces no `bank_req` and does not change the row or the words of the refill in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request from the cache side |
| req_addr | input | ADDR_W (16) | Word address of the request; the low two bits are ignored |
| busy | output | 1 | High while a refill is in flight; requests are refused while high |
| bank_req | output | 1 | One-cycle strobe that sends the row address to all banks |
| bank_row | output | ADDR_W-2 (14) | Row index broadcast to every bank |
| bank_rdata | input | NUM_BANKS*DATA_W (128) | Read data lanes; lane k comes from bank k |
| rsp_valid | output | 1 | A block word is on `rsp_data` |
| rsp_last | output | 1 | Marks the fourth and final word of a block |
| rsp_data | output | DATA_W (32) | Returned block word |

## Verification
The assertions assume the banks behave as the timing model requires. Each bank delivers its word within six cycles of the address strobe and holds it until the next strobe. The controller samples the lanes without any handshake, so nothing in the design can detect a slow bank. The bench meets this assumption with a bank model that drives a recognisable garbage pattern for six cycles after each strobe and then holds the correct word. Because of the garbage pattern, any early sampling shows up as a data mismatch. On the request side, the stimulus raises `req_valid` freely while `busy` is high, including a long stretch where it stays high continuously. This exercises the refusal path without violating any assumption, since the controller is meant to ignore such requests.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2,
        PH_XFER = 2'd3
    } phase_e;

endpackage

// File: rtl/ilv_word_sel.sv
module ilv_word_sel #(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_BANKS*DATA_W-1:0] lanes,
    input  logic [IDX_W-1:0]            idx,
    output logic [DATA_W-1:0]           word
);

    logic [DATA_W-1:0] lane_arr [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
        assign lane_arr[b] = lanes[b*DATA_W +: DATA_W];
    end

    always_comb begin
        word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (idx == IDX_W'(b)) begin
                word = lane_arr[b];
            end
        end
    end

endmodule

// File: rtl/ilv_fetch_seq.sv
module ilv_fetch_seq
    import ilv_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ACCESS_LAT = 6,
    parameter int ROW_W      = 14,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [DATA_W-1:0] word_in,
    output logic [IDX_W-1:0]  word_idx,
    output logic              busy,
    output logic              bank_req,
    output logic [ROW_W-1:0]  bank_row,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int CNT_W = (ACCESS_LAT < 2) ? 1 : $clog2(ACCESS_LAT);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_BANKS - 1);
    localparam logic [CNT_W-1:0] WAIT_INIT = CNT_W'(ACCESS_LAT - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [ROW_W-1:0]    row;
        logic                vld;
        logic                lst;
        logic [DATA_W-1:0]   data;
    } seq_t;

    seq_t s_d, s_q;

    assign busy     = (s_q.phase != PH_IDLE) || s_q.vld;
    assign bank_req = (s_q.phase == PH_SEND);
    assign bank_row = s_q.row;
    assign word_idx = s_q.idx;
    assign rsp_valid = s_q.vld;
    assign rsp_last  = s_q.lst;
    assign rsp_data  = s_q.data;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.lst = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid && !busy) begin
                    s_d.phase = PH_SEND;
                    s_d.row   = req_row;
                end
            end
            PH_SEND: begin
                s_d.phase = PH_WAIT;
                s_d.cnt   = WAIT_INIT;
            end
            PH_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_XFER;
                    s_d.idx   = '0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_XFER: begin
                s_d.vld  = 1'b1;
                s_d.data = word_in;
                s_d.lst  = (s_q.idx == LAST_IDX);
                if (s_q.idx == LAST_IDX) begin
                    s_d.phase = PH_IDLE;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int NUM_BANKS  = 4,
    parameter int ACCESS_LAT = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          busy,
    output logic                          bank_req,
    output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] bank_row,
    input  logic [NUM_BANKS*DATA_W-1:0]   bank_rdata,
    output logic                          rsp_valid,
    output logic                          rsp_last,
    output logic [DATA_W-1:0]             rsp_data
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    logic [BANK_W-1:0] unused_low_bits;
    logic [ROW_W-1:0]  req_row;
    logic [BANK_W-1:0] word_idx;
    logic [DATA_W-1:0] sel_word;

    assign unused_low_bits = req_addr[BANK_W-1:0];
    assign req_row         = req_addr[ADDR_W-1:BANK_W];

    ilv_word_sel #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W),
        .IDX_W     (BANK_W)
    ) u_sel (
        .lanes (bank_rdata),
        .idx   (word_idx),
        .word  (sel_word)
    );

    ilv_fetch_seq #(
        .NUM_BANKS  (NUM_BANKS),
        .ACCESS_LAT (ACCESS_LAT),
        .ROW_W      (ROW_W),
        .DATA_W     (DATA_W),
        .IDX_W      (BANK_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_row   (req_row),
        .word_in   (sel_word),
        .word_idx  (word_idx),
        .busy      (busy),
        .bank_req  (bank_req),
        .bank_row  (bank_row),
        .rsp_valid (rsp_valid),
        .rsp_last  (rsp_last),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/ilv_block_fetch_chk.sv
module ilv_block_fetch_chk #(
    parameter int NUM_BANKS  = 4,
    parameter int ACCESS_LAT = 6
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic bank_req,
    input logic rsp_valid,
    input logic rsp_last
);

    logic [15:0] since_q;
    logic [15:0] words_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            words_q <= '0;
        end else begin
            if (bank_req) begin
                since_q <= 16'd1;
            end else if (since_q != '0 && since_q != 16'hFFFF) begin
                since_q <= since_q + 16'd1;
            end
            if (rsp_last) begin
                words_q <= '0;
            end else if (rsp_valid) begin
                words_q <= words_q + 16'd1;
            end
        end
    end

    a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && bank_req));

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req |=> !bank_req);

    a_r9_strobe_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req |-> $past(req_valid && !busy));

    a_r5_first_word_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (since_q == 16'(ACCESS_LAT + 2)));

    a_r5_burst_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> rsp_valid);

    a_r7_last_is_fourth: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> (rsp_valid && words_q == 16'(NUM_BANKS - 1)));

    a_r8_busy_covers_words: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    a_r8_busy_drops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> !busy);

endmodule

bind ilv_block_fetch ilv_block_fetch_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .ACCESS_LAT (ACCESS_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .bank_req  (bank_req),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last)
);

// File: tb/tb_ilv_block_fetch.sv
`timescale 1ns/1ps
module tb_ilv_block_fetch;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NB     = 4;
    localparam int LAT    = 6;
    localparam int ROW_W  = ADDR_W - 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic                 busy;
    logic                 bank_req;
    logic [ROW_W-1:0]     bank_row;
    logic [NB*DATA_W-1:0] bank_rdata;
    logic                 rsp_valid;
    logic                 rsp_last;
    logic [DATA_W-1:0]    rsp_data;

    always #5 clk = ~clk;

    ilv_block_fetch dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .busy       (busy),
        .bank_req   (bank_req),
        .bank_row   (bank_row),
        .bank_rdata (bank_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_last   (rsp_last),
        .rsp_data   (rsp_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    function automatic logic [31:0] bank_word(input int bank, input int row);
        return 32'((row * 4 + bank) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // bank model: fixed access time, holds its word until the next strobe
    int bcnt  = 0;
    bit armed = 1'b0;
    int brow  = 0;
    always @(posedge clk) begin
        if (bank_req) begin
            bcnt  <= LAT;
            armed <= 1'b1;
            brow  <= int'(bank_row);
        end else if (bcnt > 0) begin
            bcnt <= bcnt - 1;
        end
    end
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_rdata[b*DATA_W +: DATA_W] = (armed && bcnt == 0) ?
                bank_word(b, brow) : (32'hBAD0_0000 | 32'(b));
        end
    end

    // reference model: distance from the accepting edge
    bit m_act = 1'b0;
    int m_d   = 0;
    int m_row = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act <= 1'b0;
            m_d   <= 0;
        end else if (!m_act && req_valid) begin
            m_act <= 1'b1;
            m_d   <= 0;
            m_row <= int'(req_addr) >> 2;
        end else if (m_act) begin
            if (m_d == 11) m_act <= 1'b0;
            else m_d <= m_d + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_busy, e_req, e_vld, e_last;
            e_busy = m_act;
            e_req  = m_act && m_d == 0;
            e_vld  = m_act && m_d >= 8;
            e_last = m_act && m_d == 11;
            chk(busy == e_busy, "R2/R8 busy", 32'(busy), 32'(e_busy));
            chk(bank_req == e_req, "R3/R9 bank_req", 32'(bank_req), 32'(e_req));
            if (e_req)
                chk(int'(bank_row) == m_row, "R3/R4 bank_row", 32'(bank_row), 32'(m_row));
            chk(rsp_valid == e_vld, "R5 rsp_valid", 32'(rsp_valid), 32'(e_vld));
            chk(rsp_last == e_last, "R7 rsp_last", 32'(rsp_last), 32'(e_last));
            if (e_vld)
                chk(rsp_data == bank_word(m_d - 8, m_row), "R6 rsp_data",
                    rsp_data, bank_word(m_d - 8, m_row));
        end
    end

    task automatic pulse_req(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] blk_a [4];
    int          got;

    initial begin
        idle(3);
        chk(!busy && !bank_req && !rsp_valid && !rsp_last, "R1 outputs in reset",
            {28'd0, busy, bank_req, rsp_valid, rsp_last}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bank_req && !rsp_valid && !rsp_last, "R1 outputs after reset",
            {28'd0, busy, bank_req, rsp_valid, rsp_last}, 32'd0);

        pulse_req(16'h0000);
        idle(14);

        // R4: same block with low bits 3, then 0; capture and compare
        pulse_req(16'h1237);
        got = 0;
        repeat (14) begin
            @(negedge clk);
            if (rsp_valid && got < 4) begin blk_a[got] = rsp_data; got++; end
        end
        pulse_req(16'h1234);
        got = 0;
        repeat (14) begin
            @(negedge clk);
            if (rsp_valid && got < 4) begin
                chk(rsp_data == blk_a[got], "R4 low bits ignored", rsp_data, blk_a[got]);
                got++;
            end
        end
        chk(got == 4, "R5 four words per block", 32'(got), 32'd4);

        // R9: request held high with changing address
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_addr  = 16'(16'h2000 + i * 5);
        end
        @(negedge clk);
        req_valid = 1'b0;
        idle(14);

        // R9: stray requests in the middle of a refill, top address
        pulse_req(16'hFFFF);
        idle(2);
        pulse_req(16'h0AB1);
        idle(4);
        pulse_req(16'h3333);
        idle(14);

        pulse_req(16'h4D52);
        idle(16);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule